// File: doc/BRIEF.md
# Single-Shot Sinc2 Conversion Filter

This block turns a 1-bit oversampled modulator stream into one 16-bit code for each conversion. A one-cycle start pulse clears the filter and begins a conversion window. Over that window the bit stream is combined with triangular weights, which is the impulse response of two equal boxcar integrate-and-dump stages in cascade. When the window closes, the weighted sum is rescaled to 16 bits and presented with a one-cycle done pulse. No filter state survives from one conversion to the next, so every code is fully settled and belongs to the samples of its own window only.

The window length is chosen per conversion by a rate input: a long window for the slow rate and a window four times shorter for the fast rate. A mode input selects the output coding. Straight binary suits a unipolar input. Offset binary suits a bipolar input, with the code range symmetric about mid-scale. Both codings saturate at the ends of the 16-bit range. The modulator is outside this block and is assumed to deliver one bit per clock.

Top module: `sinc2_conv`

## Requirements
- R1: After reset, `result` is 0 and `done` is 0.
- R2: `done` is high for exactly one cycle, on the (OSR+1)-th rising edge after the edge that samples `start`. `result` changes only on that edge and holds its value until the next `done`.
- R3: The conversion samples `bit_in` on the OSR rising edges that follow the start edge, with sample index k = 0..OSR-1. It forms S = sum of bit_k·w(k), where M = OSR/2, w(k) = k for k < M and w(k) = 2M − k for k ≥ M.
- R4: OSR is 8192 when `rate_fast` is 0 and 2048 when `rate_fast` is 1.
- R5: With `diff_mode` = 0 (straight binary), the code is min(floor(65536·S/M²), 65535).
- R6: With `diff_mode` = 1 (offset binary), the code is floor(65535·S/M²), which equals floor(32767.5·x + 32767.5) for x = 2S/M² − 1. A stream whose weighted sum is exactly mid-scale (S = M²/2) gives 32767 in this mode and 32768 in straight binary.
- R7: An all-ones stream gives 65535 and an all-zeros stream gives 0, in both modes and at both rates.
- R8: `rate_fast` and `diff_mode` are captured on the start edge. Changes to them during a conversion affect neither its length nor its code.
- R9: A `start` pulse during a conversion discards the samples already taken and begins a new full-length window. The code then depends only on the new window.
- R10: Back-to-back conversions are independent. A conversion's code does not depend on any earlier conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one modulator sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears the filter and begins a conversion |
| rate_fast | input | 1 | 0: 8192-sample window, 1: 2048-sample window |
| diff_mode | input | 1 | 0: straight binary code, 1: offset binary code |
| bit_in | input | 1 | Modulator bit stream |
| result | output | 16 | Code of the last completed conversion |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The hardest situation to reach from the ports is a conversion whose captured settings differ from the live inputs. A restart must land partway through a window that has already collected a heavy weighted sum. The stimulus toggles `rate_fast` and `diff_mode` in the middle of a slow window, and the code and the done edge must still follow the settings captured at the start. The restart case feeds a long run of ones, pulses `start` again, and then supplies zeros, so that any leftover sum would show up as a nonzero code. An alternating stream is used because its triangular weighting lands exactly on mid-scale, which separates the two codings by one count.

// File: rtl/sinc2_pkg.sv
// Shared constants and helpers for the single-shot sinc2 conversion filter.
// Assumes the output code is always 16 bits wide.
package sinc2_pkg;
    localparam int CODE_W   = 16;
    localparam int CODE_MAX = 65535;

    typedef logic [CODE_W-1:0] code_t;

    // Saturate a wide unsigned value into the 16-bit code range.
    function automatic code_t sat_code(input logic [63:0] v);
        if (v > 64'(CODE_MAX)) begin
            return code_t'(CODE_MAX);
        end
        return code_t'(v);
    endfunction
endpackage

// File: rtl/sinc2_tri_weight.sv
// Window sequencer and triangular weight source for one conversion.
// Assumes clear and step are never high together (clear wins if they are).
// The triangular weight is the cascade of two boxcars of half-window length.
module sinc2_tri_weight #(
    parameter int SLOW_LOG2 = 13,
    parameter int FAST_LOG2 = 11,
    localparam int IDX_W = SLOW_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             fast,
    output logic [IDX_W-1:0] weight,
    output logic             last
);
    localparam logic [IDX_W-1:0] OSR_SLOW = IDX_W'(1) << SLOW_LOG2;
    localparam logic [IDX_W-1:0] OSR_FAST = IDX_W'(1) << FAST_LOG2;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] osr;
    logic [IDX_W-1:0] half;

    // Sample index within the window: cleared at start, advanced per sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Window length, triangular weight for the current index, end of window.
    always_comb begin
        osr    = fast ? OSR_FAST : OSR_SLOW;
        half   = osr >> 1;
        weight = (idx_q < half) ? idx_q : (osr - idx_q);
        last   = (idx_q == osr - 1'b1);
    end
endmodule

// File: rtl/sinc2_wacc.sv
// Weighted accumulator: adds the current weight for each one-bit.
// Assumes the full-scale sum (half-window squared) fits in ACC_W bits.
module sinc2_wacc #(
    parameter int W_W   = 14,
    parameter int ACC_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             bit_in,
    input  logic [W_W-1:0]   weight,
    output logic [ACC_W-1:0] acc
);
    // Clear at a conversion start, add the weight for each sampled one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
        end else if (en && bit_in) begin
            acc <= acc + ACC_W'(weight);
        end
    end
endmodule

// File: rtl/sinc2_scale.sv
// Rescales the weighted sum to a 16-bit code for the selected rate and coding.
// Each rate variant is generated with its own shift. Assumes a log2 window >= 9.
module sinc2_scale
    import sinc2_pkg::*;
#(
    parameter int SLOW_LOG2 = 13,
    parameter int FAST_LOG2 = 11,
    parameter int ACC_W     = 27
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             fast,
    input  logic             diff,
    output code_t            code
);
    localparam int PROD_W = ACC_W + CODE_W;

    code_t code_v [2];

    for (genvar r = 0; r < 2; r++) begin : g_rate
        localparam int L      = (r == 1) ? FAST_LOG2 : SLOW_LOG2;
        localparam int FS_SH  = 2 * L - 2;
        localparam int BIN_SH = FS_SH - CODE_W;

        logic [PROD_W-1:0] prod;
        logic [PROD_W-1:0] off_q;
        logic [PROD_W-1:0] bin_q;

        // Offset binary: floor(65535*S/M^2); straight binary: floor(65536*S/M^2).
        always_comb begin
            prod  = PROD_W'(acc) * PROD_W'(CODE_MAX);
            off_q = prod >> FS_SH;
            bin_q = PROD_W'(acc) >> BIN_SH;
            code_v[r] = diff ? sat_code(64'(off_q)) : sat_code(64'(bin_q));
        end
    end

    // Select the variant matching the captured rate.
    always_comb code = fast ? code_v[1] : code_v[0];
endmodule

// File: rtl/sinc2_conv.sv
// Single-shot sinc2 conversion filter, top level.
// A start pulse clears the filter and captures rate and coding. One bit is
// sampled per clock for the window length, then the code is registered with a
// one-cycle done pulse. Assumes the modulator delivers one bit per clock.
module sinc2_conv
    import sinc2_pkg::*;
#(
    parameter int SLOW_LOG2 = 13,
    parameter int FAST_LOG2 = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rate_fast,
    input  logic        diff_mode,
    input  logic        bit_in,
    output logic [15:0] result,
    output logic        done
);
    localparam int IDX_W = SLOW_LOG2 + 1;
    localparam int ACC_W = 2 * SLOW_LOG2 + 1;

    logic             busy_q;
    logic             fin_q;
    logic             rate_q;
    logic             diff_q;
    logic             done_q;
    code_t            result_q;
    logic [IDX_W-1:0] weight;
    logic             last;
    logic [ACC_W-1:0] acc;
    code_t            code;
    logic             sample_en;

    assign sample_en = busy_q && !start;

    sinc2_tri_weight #(
        .SLOW_LOG2(SLOW_LOG2),
        .FAST_LOG2(FAST_LOG2)
    ) u_weight (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .step  (sample_en),
        .fast  (rate_q),
        .weight(weight),
        .last  (last)
    );

    sinc2_wacc #(
        .W_W  (IDX_W),
        .ACC_W(ACC_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .en    (sample_en),
        .bit_in(bit_in),
        .weight(weight),
        .acc   (acc)
    );

    sinc2_scale #(
        .SLOW_LOG2(SLOW_LOG2),
        .FAST_LOG2(FAST_LOG2),
        .ACC_W    (ACC_W)
    ) u_scale (
        .acc (acc),
        .fast(rate_q),
        .diff(diff_q),
        .code(code)
    );

    // Conversion control: capture settings at start, close the window on the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
            rate_q <= 1'b0;
            diff_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            fin_q  <= 1'b0;
            rate_q <= rate_fast;
            diff_q <= diff_mode;
        end else if (busy_q && last) begin
            busy_q <= 1'b0;
            fin_q  <= 1'b1;
        end else begin
            fin_q  <= 1'b0;
        end
    end

    // Output register: load the scaled code and pulse done one cycle after the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= fin_q;
            if (fin_q) begin
                result_q <= code;
            end
        end
    end

    assign result = result_q;
    assign done   = done_q;
endmodule

// File: rtl/sinc2_conv_chk.sv
// Temporal checks on the conversion control and the output handshake.
module sinc2_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        fin,
    input logic        rate_q,
    input logic        diff_q,
    input logic [15:0] result,
    input logic        done
);
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R2
    done_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fin));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !fin) |=> !done);

    // R8
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> ($stable(rate_q) && $stable(diff_q)));

    // R9
    restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

bind sinc2_conv sinc2_conv_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy_q),
    .fin   (fin_q),
    .rate_q(rate_q),
    .diff_q(diff_q),
    .result(result),
    .done  (done)
);

// File: tb/tb_sinc2_conv.sv
module tb_sinc2_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rate_fast = 1'b0;
    logic        diff_mode = 1'b0;
    logic        bit_in = 1'b0;
    logic [15:0] result;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sinc2_conv dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rate_fast(rate_fast),
        .diff_mode(diff_mode),
        .bit_in   (bit_in),
        .result   (result),
        .done     (done)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Stream patterns: 0 zeros, 1 ones, 2 ones at even index, 3 irregular, 4 first half only.
    function automatic bit pat(input int kind, input int k, input int osr);
        case (kind)
            0: return 1'b0;
            1: return 1'b1;
            2: return (k % 2) == 0;
            3: return ((k * 7) % 13) < 5;
            default: return k < osr / 2;
        endcase
    endfunction

    // Expected code from the weighting and coding rules (R3..R6).
    function automatic longint model(input bit fast, input bit diff, input int kind);
        int     osr = fast ? 2048 : 8192;
        longint m   = osr / 2;
        longint s   = 0;
        longint c;
        for (int k = 0; k < osr; k++) begin
            if (pat(kind, k, osr)) s += (k < m) ? k : (2 * m - k);
        end
        if (diff) c = (65535 * s) / (m * m);
        else      c = (65536 * s) / (m * m);
        if (c > 65535) c = 65535;
        return c;
    endfunction

    // Run one conversion; checks done timing, pulse width and hold (R2, R4).
    // flip: toggle rate/mode inputs mid-window (R8).
    task automatic run_conv(input string tag, input bit fast, input bit diff,
                            input int kind, input bit flip, output longint code);
        int osr = fast ? 2048 : 8192;
        @(negedge clk);
        rate_fast = fast;
        diff_mode = diff;
        start = 1'b1;
        @(posedge clk);
        for (int k = 0; k < osr; k++) begin
            @(negedge clk);
            start  = 1'b0;
            bit_in = pat(kind, k, osr);
            if (flip && k == 100) begin
                rate_fast = ~fast;
                diff_mode = ~diff;
            end
            @(posedge clk);
        end
        @(negedge clk);
        check({tag, " R2 done low before window end"}, done, 0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R2 R4 done at window end"}, done, 1);
        code = result;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R2 done single cycle"}, done, 0);
        check({tag, " R2 result held"}, result, code);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 result reset", result, 0);
        check("R1 done reset", done, 0);
    endtask

    task automatic t_extremes();
        longint c;
        run_conv("ones slow bin", 0, 0, 1, 0, c); check("R7 ones slow bin", c, 65535);
        run_conv("ones fast diff", 1, 1, 1, 0, c); check("R7 ones fast diff", c, 65535);
        run_conv("zeros fast bin", 1, 0, 0, 0, c); check("R7 zeros fast bin", c, 0);
        run_conv("zeros slow diff", 0, 1, 0, 0, c); check("R7 zeros slow diff", c, 0);
    endtask

    task automatic t_midscale();
        longint c;
        run_conv("mid fast bin", 1, 0, 2, 0, c);
        check("R5 mid-scale straight binary", c, 32768);
        run_conv("mid fast diff", 1, 1, 2, 0, c);
        check("R6 mid-scale offset binary", c, 32767);
        run_conv("mid slow diff", 0, 1, 2, 0, c);
        check("R6 R4 mid-scale slow offset binary", c, 32767);
    endtask

    task automatic t_weighting();
        longint c;
        run_conv("irr fast bin", 1, 0, 3, 0, c); check("R3 R5 irregular fast", c, model(1, 0, 3));
        run_conv("irr fast diff", 1, 1, 3, 0, c); check("R3 R6 irregular fast", c, model(1, 1, 3));
        run_conv("half fast bin", 1, 0, 4, 0, c); check("R3 first half fast", c, model(1, 0, 4));
        run_conv("irr slow bin", 0, 0, 3, 0, c); check("R3 R4 irregular slow", c, model(0, 0, 3));
    endtask

    task automatic t_latch();
        longint c;
        run_conv("latch slow bin", 0, 0, 3, 1, c);
        check("R8 settings captured at start", c, model(0, 0, 3));
    endtask

    task automatic t_restart();
        longint c;
        @(negedge clk);
        rate_fast = 1'b1; diff_mode = 1'b0; start = 1'b1;
        @(posedge clk);
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            start = 1'b0;
            bit_in = 1'b1;
            @(posedge clk);
        end
        run_conv("restart zeros", 1, 0, 0, 0, c);
        check("R9 restart discards earlier samples", c, 0);
    endtask

    task automatic t_independent();
        longint c;
        run_conv("prev ones", 1, 1, 1, 0, c);
        run_conv("next irr", 1, 1, 3, 0, c);
        check("R10 no history between conversions", c, model(1, 1, 3));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_extremes();
        t_midscale();
        t_weighting();
        t_latch();
        t_restart();
        t_independent();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule